// File: doc/BRIEF.md
# PCI Memory Target Cycle Controller

This block is the target side of a 32-bit PCI bus for one memory window. It watches the shared bus for an address phase and compares the upper address bits with a base address set by a parameter. When the address falls inside the window and the command is a memory read or a memory write, the block claims the transaction with medium-speed device select. It then runs the handshake for each data phase and passes words to or from a simple local storage port behind it. The block has no pads of its own. It drives separate output-enable signals for the address/data lines and for its control lines, and the surrounding I/O ring turns these into tri-state drivers.

Read data comes from the local port with a fixed latency of one cycle. The block prefetches the next word during each read data phase, so a read burst runs at one word per clock once the initiator is ready. The block asks the initiator to end a burst in three cases. The first is when the burst reaches a parameterised number of data phases. The second is when the current word is the last word of the window. The third is when the initiator asks for a burst order other than linear.

Top module: `pcit_target`

## Requirements
- R1: The block claims a transaction with medium timing. DEVSEL# (`devsel_n`) stays high in the first cycle after the address phase and goes low in the second cycle after it.
- R2: For a read, the block does not drive AD and keeps TRDY# high in the cycle after the address phase. In the cycle after that, `ad_oe` is 1, TRDY# is low, and `ad_out` holds the addressed word.
- R3: A data word moves only on a clock where both IRDY# and TRDY# are low. For a write, the local port receives exactly one write for each such clock.
- R4: Once TRDY# is low for a read and IRDY# is still high, TRDY# stays low and `ad_out` does not change until the transfer happens.
- R5: For a write, only the bytes whose active-low C/BE# bit is 0 reach the local storage (bit n enables AD[8n+7:8n]). For a read, all 32 bits come back whatever the byte enables are.
- R6: STOP# goes low together with TRDY# in three cases: in data phase number MAX_BURST, on the last word of the window, or in the first phase if AD[1:0] was not 00 at the address phase. If FRAME# is still low when that word transfers, the next cycle has TRDY# high while STOP# and DEVSEL# stay low. STOP# stays low until FRAME# is high.
- R7: After the final data phase (FRAME# high and IRDY# low, with TRDY# or STOP# low), DEVSEL#, TRDY# and STOP# are all high in the next cycle. A synchronous reset at any point returns the block to idle with every output enable at 0.
- R8: The block ignores a transaction whose AD[31:WIN_BITS] does not equal the base address, or whose command on C/BE# is not one of these: 0110, 1100 and 1110 for reads, 0111 and 1111 for writes. For an ignored transaction DEVSEL# never goes low and the local storage is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | FRAME# from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as seen from the bus |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_out | output | 32 | Read data to drive onto AD |
| ad_oe | output | 1 | Enable for the AD drivers |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |
| ctl_oe | output | 1 | Enable for the DEVSEL#/TRDY#/STOP# drivers |
| loc_addr | output | WIN_BITS-2 | Word address to local storage |
| loc_rd | output | 1 | Local read request; data returns one cycle later |
| loc_wr | output | 1 | Local write strobe |
| loc_wdata | output | 32 | Local write data |
| loc_be | output | 4 | Local byte enables, active high |
| loc_rdata | input | 32 | Local read data |

## Verification
The handshake is tried with initiators that are ready at once and with initiators that hold IRDY# off for one or more cycles. Wait states show whether read data and TRDY# are held steady or move to the next word early. Bursts are run that end by FRAME#, by the burst limit, at the top of the window, and through a non-linear order request. These separate the three stop causes and both endings, with and without a trailing cycle that carries no data. Writes with partial or empty byte enables, followed by read-back, tell byte masking apart from whole-word handling. A window miss and an I/O command that hits the window show that claiming depends on both the address and the command.

// File: rtl/pcit_pkg.sv
`timescale 1ns/1ps
package pcit_pkg;

    localparam int AD_W = 32;
    localparam int BE_W = AD_W / 8;

    // bus commands that the target accepts (sampled on C/BE# in the address phase)
    localparam logic [3:0] CMD_MRD  = 4'b0110;
    localparam logic [3:0] CMD_MWR  = 4'b0111;
    localparam logic [3:0] CMD_MRDM = 4'b1100;
    localparam logic [3:0] CMD_MRDL = 4'b1110;
    localparam logic [3:0] CMD_MWRI = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_DATA,
        ST_BACKOFF,
        ST_RELEASE,
        ST_SKIP
    } tst_e;

    typedef struct packed {
        logic claim;
        logic is_read;
        logic single;
    } dec_t;

    function automatic dec_t classify(input logic [3:0] cmd);
        dec_t d;
        d = '0;
        case (cmd)
            CMD_MRD, CMD_MRDM, CMD_MRDL: begin
                d.claim   = 1'b1;
                d.is_read = 1'b1;
            end
            CMD_MWR, CMD_MWRI: d.claim = 1'b1;
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcit_decode.sv
`timescale 1ns/1ps
module pcit_decode
    import pcit_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
    parameter int          WIN_BITS  = 8
) (
    input  logic [AD_W-1:0]     addr,
    input  logic [3:0]          cmd,
    output dec_t                dec,
    output logic [WIN_BITS-3:0] word
);

    logic hit;

    assign hit  = (addr[AD_W-1:WIN_BITS] == BASE_ADDR[AD_W-1:WIN_BITS]);
    assign word = addr[WIN_BITS-1:2];

    always_comb begin
        dec        = classify(cmd);
        dec.claim  = dec.claim & hit;
        // any burst order other than linear gets one word only
        dec.single = (addr[1:0] != 2'b00);
    end

endmodule

// File: rtl/pcit_fsm.sv
`timescale 1ns/1ps
module pcit_fsm
    import pcit_pkg::*;
#(
    parameter int WIN_BITS  = 8,
    parameter int MAX_BURST = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  dec_t                dec,
    input  logic [WIN_BITS-3:0] dec_word,
    output tst_e                state,
    output logic                rd_dir,
    output logic [WIN_BITS-3:0] word,
    output logic                stop_req,
    output logic                xfer
);

    localparam int LAW = WIN_BITS - 2;
    localparam int CW  = $clog2(MAX_BURST + 1);

    tst_e          nxt;
    logic [CW-1:0] beat;
    logic          one_shot;
    logic          start;
    logic          in_data;

    assign in_data  = (state == ST_DATA);
    // TRDY# is low for the whole data state, so IRDY# alone decides a transfer
    assign xfer     = in_data && !irdy_n;
    assign start    = ((state == ST_IDLE) || (state == ST_RELEASE)) && !frame_n && irdy_n;
    assign stop_req = in_data && (one_shot || (beat == CW'(MAX_BURST - 1)) || (&word));

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE, ST_RELEASE: begin
                if (start) nxt = dec.claim ? ST_TURN : ST_SKIP;
                else       nxt = ST_IDLE;
            end
            ST_TURN: nxt = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    if (frame_n)       nxt = ST_RELEASE;
                    else if (stop_req) nxt = ST_BACKOFF;
                end
            end
            ST_BACKOFF: if (frame_n) nxt = ST_RELEASE;
            ST_SKIP:    if (frame_n && irdy_n) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            word     <= '0;
            beat     <= '0;
            rd_dir   <= 1'b0;
            one_shot <= 1'b0;
        end else begin
            state <= nxt;
            if (start && dec.claim) begin
                word     <= dec_word;
                beat     <= '0;
                rd_dir   <= dec.is_read;
                one_shot <= dec.single;
            end else if (xfer && !frame_n && !stop_req) begin
                word <= word + LAW'(1);
                beat <= beat + CW'(1);
            end
        end
    end

endmodule

// File: rtl/pcit_rdpath.sv
`timescale 1ns/1ps
module pcit_rdpath
    import pcit_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            turn,
    input  logic            in_data,
    input  logic            xfer,
    input  logic [AD_W-1:0] loc_rdata,
    output logic [AD_W-1:0] rd_word
);

    logic            fresh_q;
    logic [AD_W-1:0] hold_q;

    // new word straight from storage in its first cycle, held copy after that
    assign rd_word = fresh_q ? loc_rdata : hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            fresh_q <= turn | xfer;
            if (in_data) hold_q <= rd_word;
        end
    end

endmodule

// File: rtl/pcit_target.sv
`timescale 1ns/1ps
module pcit_target
    import pcit_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
    parameter int          WIN_BITS  = 8,
    parameter int          MAX_BURST = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic [31:0]         ad_in,
    input  logic [3:0]          cbe_n,
    output logic [31:0]         ad_out,
    output logic                ad_oe,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n,
    output logic                ctl_oe,
    output logic [WIN_BITS-3:0] loc_addr,
    output logic                loc_rd,
    output logic                loc_wr,
    output logic [31:0]         loc_wdata,
    output logic [3:0]          loc_be,
    input  logic [31:0]         loc_rdata
);

    localparam int LAW = WIN_BITS - 2;

    dec_t           dec;
    logic [LAW-1:0] dec_word;
    tst_e           st;
    logic           rd_dir;
    logic [LAW-1:0] word;
    logic           stop_req;
    logic           xfer;
    logic [31:0]    rd_word;

    pcit_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) dec_i (
        .addr (ad_in),
        .cmd  (cbe_n),
        .dec  (dec),
        .word (dec_word)
    );

    pcit_fsm #(.WIN_BITS(WIN_BITS), .MAX_BURST(MAX_BURST)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .dec      (dec),
        .dec_word (dec_word),
        .state    (st),
        .rd_dir   (rd_dir),
        .word     (word),
        .stop_req (stop_req),
        .xfer     (xfer)
    );

    pcit_rdpath rd_i (
        .clk       (clk),
        .rst       (rst),
        .turn      (st == ST_TURN),
        .in_data   (st == ST_DATA),
        .xfer      (xfer),
        .loc_rdata (loc_rdata),
        .rd_word   (rd_word)
    );

    always_comb begin
        ctl_oe   = (st == ST_TURN) || (st == ST_DATA) || (st == ST_BACKOFF) || (st == ST_RELEASE);
        devsel_n = !((st == ST_DATA) || (st == ST_BACKOFF));
        trdy_n   = !(st == ST_DATA);
        stop_n   = !(stop_req || (st == ST_BACKOFF));
        ad_oe    = rd_dir && (st == ST_DATA);
        ad_out   = rd_word;

        // reads fetch the first word during turnaround, then one word ahead
        loc_rd    = rd_dir && ((st == ST_TURN) || (st == ST_DATA));
        loc_addr  = (rd_dir && (st == ST_DATA)) ? word + LAW'(1) : word;
        loc_wr    = !rd_dir && xfer;
        loc_wdata = ad_in;
        loc_be    = ~cbe_n;
    end

endmodule

// File: rtl/pcit_target_chk.sv
`timescale 1ns/1ps
module pcit_target_chk
    import pcit_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        ctl_oe,
    input logic        ad_oe,
    input logic        loc_wr,
    input logic [31:0] ad_out,
    input tst_e        st
);

    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TURN) |-> (devsel_n && trdy_n && !ad_oe)); // R2

    AST_MEDIUM_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TURN) |=> !devsel_n); // R1

    AST_WR_ON_XFER: assert property (@(posedge clk) disable iff (rst)
        loc_wr |-> (!irdy_n && !trdy_n)); // R3

    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out))); // R4

    AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !frame_n) |=> !stop_n); // R6

    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && !irdy_n && frame_n && (!trdy_n || !stop_n)) |=> devsel_n); // R7

    AST_IGNORED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> (devsel_n && !ctl_oe && !loc_wr)); // R8

endmodule

bind pcit_target pcit_target_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .ctl_oe   (ctl_oe),
    .ad_oe    (ad_oe),
    .loc_wr   (loc_wr),
    .ad_out   (ad_out),
    .st       (st)
);

// File: tb/pcit_target_tb_top.sv
`timescale 1ns/1ps
module pcit_target_tb_top;

    localparam logic [31:0] BASE  = 32'h8000_0000;
    localparam int          WINB  = 8;
    localparam int          MAXB  = 4;
    localparam int          WORDS = 1 << (WINB - 2);
    localparam int          NVEC  = 12;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [3:0]  nb;
        logic [7:0]  waits;
        logic [3:0]  be;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'h7, 32'h8000_0010, 4'd2, 8'h00, 4'hF, 32'h1111_0000},
        '{4'h6, 32'h8000_0010, 4'd2, 8'h00, 4'hF, 32'h0},
        '{4'hF, 32'h8000_0040, 4'd6, 8'h04, 4'hF, 32'h2222_0000},
        '{4'hC, 32'h8000_0040, 4'd6, 8'h0A, 4'hF, 32'h0},
        '{4'h7, 32'h8000_00F8, 4'd4, 8'h00, 4'h5, 32'h3333_3333},
        '{4'hE, 32'h8000_00F8, 4'd4, 8'h02, 4'hF, 32'h0},
        '{4'h7, 32'h9000_0010, 4'd1, 8'h00, 4'hF, 32'h4444_4444},
        '{4'h2, 32'h8000_0000, 4'd1, 8'h00, 4'hF, 32'h0},
        '{4'h6, 32'h8000_0021, 4'd3, 8'h03, 4'hF, 32'h0},
        '{4'h7, 32'h8000_0014, 4'd1, 8'h01, 4'h8, 32'h5555_6666},
        '{4'h6, 32'h8000_0014, 4'd1, 8'h00, 4'h0, 32'h0},
        '{4'h3, 32'h8000_0018, 4'd1, 8'h00, 4'hF, 32'h7777_7777}
    };

    logic                clk = 1'b0;
    logic                rst;
    logic                frame_n, irdy_n;
    logic [31:0]         ad_in;
    logic [3:0]          cbe_n;
    logic [31:0]         ad_out;
    logic                ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;
    logic [WINB-3:0]     loc_addr;
    logic                loc_rd, loc_wr;
    logic [31:0]         loc_wdata;
    logic [3:0]          loc_be;
    logic [31:0]         loc_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pcit_target #(.BASE_ADDR(BASE), .WIN_BITS(WINB), .MAX_BURST(MAXB)) dut_i (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
        .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr),
        .loc_wdata(loc_wdata), .loc_be(loc_be), .loc_rdata(loc_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0000_0111;
    endfunction

    // local storage model: one-cycle read latency, byte-masked writes
    logic [31:0] mem [WORDS];
    logic [31:0] rdq;
    logic [31:0] ref_mem [WORDS];
    assign loc_rdata = rdq;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i);
            rdq <= '0;
        end else begin
            if (loc_wr)
                for (int b = 0; b < 4; b++)
                    if (loc_be[b]) mem[loc_addr][8*b +: 8] <= loc_wdata[8*b +: 8];
            if (loc_rd) rdq <= mem[loc_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic ref_reset();
        for (int i = 0; i < WORDS; i++) ref_mem[i] = init_word(i);
    endtask

    task automatic run_vec(input vec_t v);
        bit is_wr, is_rd, hit, done, stop_seen, dev_seen, hold_pend, back_pend, wr_stray;
        int w0, expn, beats, w, mism;
        logic [31:0] hold_val, wd;
        is_wr = (v.cmd == 4'h7) || (v.cmd == 4'hF);
        is_rd = (v.cmd == 4'h6) || (v.cmd == 4'hC) || (v.cmd == 4'hE);
        hit   = (v.addr[31:WINB] == BASE[31:WINB]) && (is_wr || is_rd);
        w0    = int'(v.addr[WINB-1:2]);
        expn  = int'(v.nb);
        if (expn > MAXB) expn = MAXB;
        if (expn > WORDS - w0) expn = WORDS - w0;
        if (v.addr[1:0] != 2'b00) expn = 1;
        if (!hit) expn = 0;
        beats = 0; done = 0; stop_seen = 0; dev_seen = 0;
        hold_pend = 0; back_pend = 0; wr_stray = 0; hold_val = '0;

        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = v.addr; cbe_n = v.cmd;
        for (int c = 1; c < 40 && !done; c++) begin
            @(negedge clk);
            if (stop_seen || (c >= 5 && !dev_seen)) begin
                frame_n = 1'b1; irdy_n = 1'b0;
            end else begin
                if (irdy_n) irdy_n = (c <= 8) ? v.waits[c-1] : 1'b0;
                if (!irdy_n && beats == int'(v.nb) - 1) frame_n = 1'b1;
            end
            cbe_n = ~v.be;
            ad_in = is_wr ? v.seed + 32'(beats) * 32'h0101_0101 : 32'h0;
            #1;
            if (!devsel_n) dev_seen = 1;
            if (loc_wr && !(!irdy_n && !trdy_n)) wr_stray = 1;
            if (c == 1)
                check(devsel_n && trdy_n && !ad_oe, "R1/R2 turnaround cycle quiet",
                      {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
            if (c == 2 && hit) begin
                check(!devsel_n, "R1 medium claim", {31'd0, devsel_n}, 32'h0);
                if (is_rd) check(!trdy_n && ad_oe, "R2 read ready after turnaround",
                                 {30'd0, trdy_n, ad_oe}, 32'h1);
            end
            if (hold_pend)
                check(!trdy_n && ad_out == hold_val, "R4 read data held", ad_out, hold_val);
            if (back_pend)
                check(trdy_n && !devsel_n && !stop_n, "R6 stop trailing cycle",
                      {29'd0, trdy_n, devsel_n, stop_n}, 32'h4);
            back_pend = 0;
            if (!irdy_n && !trdy_n) begin
                w = (w0 + beats) % WORDS;
                if (is_rd) begin
                    check(ad_out == ref_mem[w], "R2/R5 read word", ad_out, ref_mem[w]);
                end else begin
                    wd = ad_in;
                    for (int b = 0; b < 4; b++)
                        if (v.be[b]) ref_mem[w][8*b +: 8] = wd[8*b +: 8];
                end
                beats++;
                if (!stop_n && !frame_n) back_pend = 1;
            end
            hold_pend = is_rd && !trdy_n && irdy_n;
            hold_val  = ad_out;
            if (frame_n && !irdy_n && (!trdy_n || !stop_n || (c >= 5 && !dev_seen))) done = 1;
            if (!stop_n) stop_seen = 1;
        end
        check(done, "R3 transaction completed", {31'd0, done}, 32'h1);
        check(beats == expn, hit ? "R6 data phase count" : "R8 ignored transaction moves no data",
              32'(beats), 32'(expn));
        if (!hit) check(!dev_seen, "R8 no claim", {31'd0, dev_seen}, 32'h0);
        check(!wr_stray, "R3 local write only on transfer", {31'd0, wr_stray}, 32'h0);

        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1;
        #1;
        check(devsel_n && trdy_n && stop_n, "R7 control released after final phase",
              {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
        @(negedge clk);
        mism = 0;
        for (int i = 0; i < WORDS; i++) if (mem[i] != ref_mem[i]) mism++;
        check(mism == 0, is_wr ? "R5 stored bytes match" : "R8 storage untouched",
              32'(mism), 32'h0);
    endtask

    initial begin
        rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = '0;
        repeat (3) @(negedge clk);
        #1;
        check(devsel_n && trdy_n && stop_n && !ad_oe && !ctl_oe, "R7 reset idle",
              {27'd0, devsel_n, trdy_n, stop_n, ad_oe, ctl_oe}, 32'h1C);
        @(negedge clk);
        rst = 1'b0;
        ref_reset();
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // reset in the middle of a read burst
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = BASE + 32'h20; cbe_n = 4'h6;
        @(negedge clk); irdy_n = 1'b1; cbe_n = 4'h0;
        @(negedge clk);
        #1;
        check(!devsel_n, "R1 claim before reset", {31'd0, devsel_n}, 32'h0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        #1;
        check(devsel_n && trdy_n && stop_n && !ad_oe && !ctl_oe, "R7 reset mid-burst",
              {27'd0, devsel_n, trdy_n, stop_n, ad_oe, ctl_oe}, 32'h1C);
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk); rst = 1'b0;
        ref_reset();
        @(negedge clk);
        run_vec(VECS[1]);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule